// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block holds the per-interrupt state of a small interrupt controller with up to 64 request lines (parameter `NUM_IRQ`, a multiple of 32). Each line can be set to edge or level capture. Captured requests go into pending bits. Software reaches the enable, pending, active, priority and trigger state through a 32-bit register bus. The bus has a byte address, a write strobe, write data and a combinational read port. Enable, pending and active each have a set window and a clear window. A 1 written into either window changes the matching bit, a 0 leaves it alone, and both windows read back the current state. The lowest `NUM_SGI` IDs are reserved for software-generated requests. They come out of reset enabled, and their trigger fields are fixed to edge.

A serial selector picks, from all interrupts that are enabled, pending and not active, the one with the lowest priority value. On a tie the lower ID wins. The selector is a three-state machine. START clears the running best and the scan index, then always moves to SCAN. SCAN examines one ID per cycle and stays in SCAN until the last ID has been examined, then moves to PUBLISH. PUBLISH copies the best result to the output registers and always returns to START. A full pass takes `NUM_IRQ`+2 cycles, so a stable request is presented within two passes.

The presented candidate is gated by the global forwarding bit and by that ID's current eligibility. The CPU-side block sends an acknowledge strobe for the presented ID: this clears its pending bit and sets its active bit. It sends a deactivate strobe with an ID to clear that ID's active bit.

Register map (byte addresses; bits [1:0] are ignored):
- Control is at 0x000.
- Enable set is at 0x100 + 4w and enable clear at 0x140 + 4w.
- Pending set is at 0x200 + 4w and pending clear at 0x240 + 4w.
- Active set is at 0x300 + 4w and active clear at 0x340 + 4w.
- Priority words are at 0x400 + 4k.
- Trigger words are at 0x600 + 4c.
- Word w covers IDs 32w to 32w+31, with ID 32w+b at bit b.

Top module: `irq_distributor`

## Requirements
- R1: After reset, enable word 0 (0x100) reads 0x0000FFFF and every other enable word reads 0. All pending, active, priority and control bits read 0, trigger word 0 (0x600) reads 0xAAAAAAAA, and `irq_valid` is 0.
- R2: Writing 1 to bit b of enable set word w (0x100+4w) enables ID 32w+b. Writing 1 to the same bit of the clear word (0x140+4w) disables it. Zero bits change nothing, and both addresses read the current enable word.
- R3: Pending has the same write-one set (0x200+4w) and clear (0x240+4w) pair, and both read back the current pending word.
- R4: Active has the same write-one set (0x300+4w) and clear (0x340+4w) pair, and both read back the current active word.
- R5: Priority word k (0x400+4k) holds four 8-bit fields. ID 4k+j uses bits [8j+7:8j]. Fields read back as written and reset to 0.
- R6: Trigger word c (0x600+4c) holds the field of ID 16c+f in bits [2f+1:2f]. Bit 2f+1 = 1 selects edge and 0 selects level, and bit 2f always reads 0. Fields of IDs below 16 read as 2'b10 and ignore writes.
- R7: An edge-configured ID becomes pending on a rising edge of its line. Holding the line high does not re-pend it after a clear.
- R8: A level-configured ID becomes pending whenever its line is high and it is not active, so a pending clear has no lasting effect while the line is high. The bit stays set after the line falls until it is cleared.
- R9: While control bit 0 is 0, `irq_valid` is 0 even though pending bits still latch.
- R10: The presented ID is the eligible ID (enabled, pending, not active) with the lowest priority value. Among equal values, the lowest ID wins.
- R11: An `ack` while `irq_valid` is 1 clears the pending bit and sets the active bit of `irq_id`. An `ack` while `irq_valid` is 0 changes nothing.
- R12: A `deact` strobe clears the active bit of `deact_id`.
- R13: An active ID is never presented, even if it is pending again, until it is deactivated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_line | input | NUM_IRQ | Interrupt request lines |
| irq_valid | output | 1 | A candidate is presented |
| irq_id | output | $clog2(NUM_IRQ) | ID of the presented candidate |
| irq_prio | output | 8 | Priority of the presented candidate |
| ack | input | 1 | Acknowledge of the presented candidate |
| deact | input | 1 | Deactivate strobe |
| deact_id | input | $clog2(NUM_IRQ) | ID to deactivate |

## Verification
The bench targets these corner cases:
- **Priority tie.** A tie between two IDs is resolved in favour of the lower ID. A selector that compared with less-or-equal would present the higher ID instead.
- **Re-pend while active.** An acknowledged ID is set pending again while it is still active. A selector that ignored the active bit would present it a second time instead of the next candidate.
- **Clear against a high line.** Pending clears are written while a line is held high. An edge input must stay clear, while a level input must re-pend at once. Swapping these two behaviours would show up as a wrong pending readback.
- **Ack with no candidate.** An acknowledge arrives while nothing is presented. A design that did not gate the acknowledge would corrupt the active and pending state.
- **Read-only fields.** Writes to the read-only low trigger fields and to the reserved trigger bits must not change their readback.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

    localparam int BUS_AW = 12;
    localparam int BUS_DW = 32;

    // Register pages, selected by bus_addr[11:8]
    localparam logic [3:0] PG_CTRL   = 4'h0;
    localparam logic [3:0] PG_ENABLE = 4'h1;
    localparam logic [3:0] PG_PEND   = 4'h2;
    localparam logic [3:0] PG_ACTIVE = 4'h3;
    localparam logic [3:0] PG_PRIO   = 4'h4;
    localparam logic [3:0] PG_TRIG   = 4'h6;

    typedef enum logic [1:0] {
        ST_START   = 2'd0,
        ST_SCAN    = 2'd1,
        ST_PUBLISH = 2'd2
    } scan_state_e;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int NUM_IRQ = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_line,
    output logic [NUM_IRQ-1:0] rise
);

    logic [NUM_IRQ-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= irq_line;
        end
    end

    assign rise = irq_line & ~prev_q;

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
    import irq_dist_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_SGI = 16,
    parameter int PRIO_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BUS_AW-1:0]         bus_addr,
    input  logic                      bus_we,
    input  logic [BUS_DW-1:0]         bus_wdata,
    output logic [BUS_DW-1:0]         bus_rdata,
    input  logic [NUM_IRQ-1:0]        irq_line,
    input  logic [NUM_IRQ-1:0]        rise,
    input  logic [NUM_IRQ-1:0]        ack_hit,
    input  logic [NUM_IRQ-1:0]        deact_hit,
    output logic                      ctrl_en,
    output logic [NUM_IRQ-1:0]        en_vec,
    output logic [NUM_IRQ-1:0]        pend_vec,
    output logic [NUM_IRQ-1:0]        act_vec,
    output logic [NUM_IRQ*PRIO_W-1:0] prio_flat
);

    localparam int NW  = NUM_IRQ / BUS_DW;        // bitmap words
    localparam int PPW = BUS_DW / PRIO_W;         // priorities per word
    localparam int NPW = NUM_IRQ / PPW;           // priority words
    localparam int TPW = BUS_DW / 2;              // trigger fields per word
    localparam int NTW = NUM_IRQ / TPW;           // trigger words

    logic [3:0] page;
    logic       clr_half;
    logic       bit_page_ok;
    logic [3:0] widx;
    logic [5:0] pidx;
    logic       unused_addr_bits;

    assign page             = bus_addr[11:8];
    assign clr_half         = bus_addr[6];
    assign bit_page_ok      = !bus_addr[7];
    assign widx             = bus_addr[5:2];
    assign pidx             = bus_addr[7:2];
    assign unused_addr_bits = ^bus_addr[1:0];

    logic wr_ctrl, wr_prio, wr_trig;
    logic wr_en_set, wr_en_clr, wr_pd_set, wr_pd_clr, wr_ac_set, wr_ac_clr;

    assign wr_ctrl   = bus_we && page == PG_CTRL && pidx == 6'd0;
    assign wr_prio   = bus_we && page == PG_PRIO;
    assign wr_trig   = bus_we && page == PG_TRIG;
    assign wr_en_set = bus_we && bit_page_ok && page == PG_ENABLE && !clr_half;
    assign wr_en_clr = bus_we && bit_page_ok && page == PG_ENABLE &&  clr_half;
    assign wr_pd_set = bus_we && bit_page_ok && page == PG_PEND   && !clr_half;
    assign wr_pd_clr = bus_we && bit_page_ok && page == PG_PEND   &&  clr_half;
    assign wr_ac_set = bus_we && bit_page_ok && page == PG_ACTIVE && !clr_half;
    assign wr_ac_clr = bus_we && bit_page_ok && page == PG_ACTIVE &&  clr_half;

    // Global forwarding bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_en <= bus_wdata[0];
        end
    end

    // Write-one masks, one 32-bit slice per bitmap word
    logic [NUM_IRQ-1:0] en_set_m, en_clr_m, pd_set_m, pd_clr_m, ac_set_m, ac_clr_m;

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic hit;
        assign hit = (int'(widx) == w);
        assign en_set_m[BUS_DW*w +: BUS_DW] = (wr_en_set && hit) ? bus_wdata : '0;
        assign en_clr_m[BUS_DW*w +: BUS_DW] = (wr_en_clr && hit) ? bus_wdata : '0;
        assign pd_set_m[BUS_DW*w +: BUS_DW] = (wr_pd_set && hit) ? bus_wdata : '0;
        assign pd_clr_m[BUS_DW*w +: BUS_DW] = (wr_pd_clr && hit) ? bus_wdata : '0;
        assign ac_set_m[BUS_DW*w +: BUS_DW] = (wr_ac_set && hit) ? bus_wdata : '0;
        assign ac_clr_m[BUS_DW*w +: BUS_DW] = (wr_ac_clr && hit) ? bus_wdata : '0;
    end

    logic [2*NUM_IRQ-1:0] trig_word;

    // Per-interrupt state
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        logic              en_q;
        logic              pend_q;
        logic              act_q;
        logic              edge_sel;
        logic              hw_set;
        logic [PRIO_W-1:0] prio_q;

        if (i < NUM_SGI) begin : g_fixed_trig
            assign edge_sel = 1'b1;
        end else begin : g_prog_trig
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    edge_sel <= 1'b0;
                end else if (wr_trig && int'(pidx) == i / TPW) begin
                    edge_sel <= bus_wdata[2*(i%TPW)+1];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q <= (i < NUM_SGI) ? 1'b1 : 1'b0;
            end else if (en_set_m[i]) begin
                en_q <= 1'b1;
            end else if (en_clr_m[i]) begin
                en_q <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q <= '0;
            end else if (wr_prio && int'(pidx) == i / PPW) begin
                prio_q <= bus_wdata[PRIO_W*(i%PPW) +: PRIO_W];
            end
        end

        // Hardware capture: edge uses the detected rise, level follows the line
        assign hw_set = edge_sel ? rise[i] : (irq_line[i] & ~act_q & ~ack_hit[i]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
                act_q  <= 1'b0;
            end else begin
                pend_q <= (pend_q & ~(pd_clr_m[i] | ack_hit[i])) | pd_set_m[i] | hw_set;
                act_q  <= (act_q & ~(ac_clr_m[i] | deact_hit[i])) | ac_set_m[i] | ack_hit[i];
            end
        end

        assign en_vec[i]                      = en_q;
        assign pend_vec[i]                    = pend_q;
        assign act_vec[i]                     = act_q;
        assign prio_flat[PRIO_W*i +: PRIO_W]  = prio_q;
        assign trig_word[2*i+1]               = edge_sel;
        assign trig_word[2*i]                 = 1'b0;
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        unique case (page)
            PG_CTRL: begin
                if (pidx == 6'd0) bus_rdata = {{(BUS_DW-1){1'b0}}, ctrl_en};
            end
            PG_ENABLE: begin
                for (int w = 0; w < NW; w++)
                    if (bit_page_ok && int'(widx) == w) bus_rdata = en_vec[BUS_DW*w +: BUS_DW];
            end
            PG_PEND: begin
                for (int w = 0; w < NW; w++)
                    if (bit_page_ok && int'(widx) == w) bus_rdata = pend_vec[BUS_DW*w +: BUS_DW];
            end
            PG_ACTIVE: begin
                for (int w = 0; w < NW; w++)
                    if (bit_page_ok && int'(widx) == w) bus_rdata = act_vec[BUS_DW*w +: BUS_DW];
            end
            PG_PRIO: begin
                for (int k = 0; k < NPW; k++)
                    if (int'(pidx) == k) bus_rdata = prio_flat[BUS_DW*k +: BUS_DW];
            end
            PG_TRIG: begin
                for (int c = 0; c < NTW; c++)
                    if (int'(pidx) == c) bus_rdata = trig_word[BUS_DW*c +: BUS_DW];
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_scan_select.sv
module irq_scan_select
    import irq_dist_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        elig,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    output logic                      pick_valid,
    output logic [$clog2(NUM_IRQ)-1:0] pick_id,
    output logic [PRIO_W-1:0]         pick_prio
);

    localparam int              ID_W    = $clog2(NUM_IRQ);
    localparam logic [ID_W-1:0] LAST_ID = ID_W'(NUM_IRQ - 1);

    scan_state_e       state_q, state_d;
    logic [ID_W-1:0]   idx_q;
    logic              best_valid_q;
    logic [ID_W-1:0]   best_id_q;
    logic [PRIO_W-1:0] best_prio_q;
    logic [PRIO_W-1:0] cur_prio;
    logic              take;

    assign cur_prio = prio_flat[idx_q*PRIO_W +: PRIO_W];
    // Strict compare: an equal value never displaces a lower ID seen earlier
    assign take     = elig[idx_q] && (!best_valid_q || cur_prio < best_prio_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_START;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_START:   state_d = ST_SCAN;
            ST_SCAN:    state_d = (idx_q == LAST_ID) ? ST_PUBLISH : ST_SCAN;
            ST_PUBLISH: state_d = ST_START;
            default:    state_d = ST_START;
        endcase
    end

    // Scan datapath and published outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q        <= '0;
            best_valid_q <= 1'b0;
            best_id_q    <= '0;
            best_prio_q  <= '0;
            pick_valid   <= 1'b0;
            pick_id      <= '0;
            pick_prio    <= '0;
        end else begin
            unique case (state_q)
                ST_START: begin
                    idx_q        <= '0;
                    best_valid_q <= 1'b0;
                end
                ST_SCAN: begin
                    if (take) begin
                        best_valid_q <= 1'b1;
                        best_id_q    <= idx_q;
                        best_prio_q  <= cur_prio;
                    end
                    idx_q <= idx_q + 1'b1;
                end
                ST_PUBLISH: begin
                    pick_valid <= best_valid_q;
                    pick_id    <= best_id_q;
                    pick_prio  <= best_prio_q;
                end
                default: begin
                    idx_q <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irq_dist_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_SGI = 16,
    parameter int PRIO_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [11:0]                bus_addr,
    input  logic                       bus_we,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [NUM_IRQ-1:0]         irq_line,
    output logic                       irq_valid,
    output logic [$clog2(NUM_IRQ)-1:0] irq_id,
    output logic [PRIO_W-1:0]          irq_prio,
    input  logic                       ack,
    input  logic                       deact,
    input  logic [$clog2(NUM_IRQ)-1:0] deact_id
);

    localparam int ID_W = $clog2(NUM_IRQ);

    logic                      ctrl_en;
    logic [NUM_IRQ-1:0]        en_vec, pend_vec, act_vec, elig;
    logic [NUM_IRQ-1:0]        rise, ack_hit, deact_hit;
    logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
    logic                      pick_valid;
    logic [ID_W-1:0]           pick_id;
    logic [PRIO_W-1:0]         pick_prio;

    irq_edge_detect #(.NUM_IRQ(NUM_IRQ)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_line (irq_line),
        .rise     (rise)
    );

    irq_state_bank #(
        .NUM_IRQ (NUM_IRQ),
        .NUM_SGI (NUM_SGI),
        .PRIO_W  (PRIO_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_line  (irq_line),
        .rise      (rise),
        .ack_hit   (ack_hit),
        .deact_hit (deact_hit),
        .ctrl_en   (ctrl_en),
        .en_vec    (en_vec),
        .pend_vec  (pend_vec),
        .act_vec   (act_vec),
        .prio_flat (prio_flat)
    );

    assign elig = en_vec & pend_vec & ~act_vec;

    irq_scan_select #(
        .NUM_IRQ (NUM_IRQ),
        .PRIO_W  (PRIO_W)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .elig       (elig),
        .prio_flat  (prio_flat),
        .pick_valid (pick_valid),
        .pick_id    (pick_id),
        .pick_prio  (pick_prio)
    );

    // A published pick is withdrawn at once if it loses eligibility
    assign irq_valid = pick_valid & ctrl_en & elig[pick_id];
    assign irq_id    = pick_id;
    assign irq_prio  = pick_prio;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_strobe
        assign ack_hit[i]   = ack & irq_valid & (irq_id == ID_W'(i));
        assign deact_hit[i] = deact & (deact_id == ID_W'(i));
    end

endmodule

// File: rtl/irq_distributor_chk.sv
module irq_distributor_chk #(
    parameter int NUM_IRQ = 64
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [11:0]                bus_addr,
    input logic                       bus_we,
    input logic [31:0]                bus_wdata,
    input logic                       irq_valid,
    input logic [$clog2(NUM_IRQ)-1:0] irq_id,
    input logic                       ack,
    input logic                       deact,
    input logic [$clog2(NUM_IRQ)-1:0] deact_id,
    input logic                       ctrl_en,
    input logic [NUM_IRQ-1:0]         en_vec,
    input logic [NUM_IRQ-1:0]         pend_vec,
    input logic [NUM_IRQ-1:0]         act_vec
);

    assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 12'h100) |=> ((en_vec[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

    assert_pend_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 12'h200) |=> ((pend_vec[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

    assert_act_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 12'h300) |=> ((act_vec[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

    assert_gate_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ctrl_en);

    assert_ack_activates_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_valid) |=> act_vec[$past(irq_id)]);

    assert_deact_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (deact && !bus_we && !(ack && irq_valid && irq_id == deact_id)) |=> !act_vec[$past(deact_id)]);

    assert_no_active_pick_R13: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (!act_vec[irq_id] && pend_vec[irq_id] && en_vec[irq_id]));

endmodule

bind irq_distributor irq_distributor_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .irq_valid (irq_valid),
    .irq_id    (irq_id),
    .ack       (ack),
    .deact     (deact),
    .deact_id  (deact_id),
    .ctrl_en   (ctrl_en),
    .en_vec    (en_vec),
    .pend_vec  (pend_vec),
    .act_vec   (act_vec)
);

// File: tb/irq_distributor_tb.sv
module irq_distributor_tb;

    localparam int NUM_IRQ = 64;
    localparam int ID_W    = $clog2(NUM_IRQ);
    localparam int SETTLE  = 2 * (NUM_IRQ + 2) + 6;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [11:0]        bus_addr = '0;
    logic               bus_we = 1'b0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [NUM_IRQ-1:0] irq_line = '0;
    logic               irq_valid;
    logic [ID_W-1:0]    irq_id;
    logic [7:0]         irq_prio;
    logic               ack = 1'b0;
    logic               deact = 1'b0;
    logic [ID_W-1:0]    deact_id = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_distributor #(.NUM_IRQ(NUM_IRQ)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_line  (irq_line),
        .irq_valid (irq_valid),
        .irq_id    (irq_id),
        .irq_prio  (irq_prio),
        .ack       (ack),
        .deact     (deact),
        .deact_id  (deact_id)
    );

    task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expected);
        checks++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, actual, expected);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] expected);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, expected);
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic out_chk(input string req, input logic v, input logic [ID_W-1:0] id, input logic [7:0] p);
        chk({req, " valid"}, {31'b0, irq_valid}, {31'b0, v});
        if (v) begin
            chk({req, " id"}, {{(32-ID_W){1'b0}}, irq_id}, {{(32-ID_W){1'b0}}, id});
            chk({req, " prio"}, {24'b0, irq_prio}, {24'b0, p});
        end
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic t_reset();
        out_chk("R1 reset out", 1'b0, '0, 8'h00);
        rd_chk("R1 enable w0", 12'h100, 32'h0000_FFFF);
        rd_chk("R1 enable w1", 12'h104, 32'h0);
        rd_chk("R1 pending w0", 12'h200, 32'h0);
        rd_chk("R1 active w1", 12'h304, 32'h0);
        rd_chk("R1 prio w0", 12'h400, 32'h0);
        rd_chk("R1 ctrl", 12'h000, 32'h0);
        rd_chk("R1 trig w0", 12'h600, 32'hAAAA_AAAA);
        rd_chk("R1 trig w2", 12'h608, 32'h0);
    endtask

    task automatic t_enable();
        wr(12'h104, 32'h30);
        rd_chk("R2 set view", 12'h104, 32'h30);
        rd_chk("R2 clear view", 12'h144, 32'h30);
        wr(12'h144, 32'h10);
        rd_chk("R2 clear one bit", 12'h104, 32'h20);
        wr(12'h104, 32'h0);
        rd_chk("R2 zero write no effect", 12'h104, 32'h20);
        wr(12'h144, 32'h20);
        rd_chk("R2 cleared", 12'h104, 32'h0);
        wr(12'h140, 32'h1);
        rd_chk("R2 clear sgi0", 12'h100, 32'h0000_FFFE);
        wr(12'h100, 32'h1);
        rd_chk("R2 restore sgi0", 12'h140, 32'h0000_FFFF);
    endtask

    task automatic t_pending();
        wr(12'h204, 32'h5);
        rd_chk("R3 set", 12'h244, 32'h5);
        wr(12'h244, 32'h1);
        rd_chk("R3 clear one", 12'h204, 32'h4);
        wr(12'h204, 32'h0);
        rd_chk("R3 zero no effect", 12'h204, 32'h4);
        wr(12'h244, 32'h4);
        rd_chk("R3 cleared", 12'h204, 32'h0);
    endtask

    task automatic t_active();
        wr(12'h300, 32'h8000_0000);
        rd_chk("R4 set", 12'h340, 32'h8000_0000);
        wr(12'h340, 32'h0);
        rd_chk("R4 zero no effect", 12'h300, 32'h8000_0000);
        wr(12'h340, 32'h8000_0000);
        rd_chk("R4 cleared", 12'h300, 32'h0);
    endtask

    task automatic t_prio();
        wr(12'h428, 32'h1122_3344);
        rd_chk("R5 readback", 12'h428, 32'h1122_3344);
        rd_chk("R5 neighbour untouched", 12'h42C, 32'h0);
        wr(12'h428, 32'h0);
        rd_chk("R5 restore", 12'h428, 32'h0);
    endtask

    task automatic t_trig();
        wr(12'h600, 32'h0);
        rd_chk("R6 low fields read only", 12'h600, 32'hAAAA_AAAA);
        wr(12'h608, 32'hFFFF_FFFF);
        rd_chk("R6 reserved bits zero", 12'h608, 32'hAAAA_AAAA);
        wr(12'h608, 32'h2);
        rd_chk("R6 id32 edge", 12'h608, 32'h2);
    endtask

    task automatic t_edge();
        @(negedge clk);
        irq_line[32] = 1'b1;
        repeat (2) @(negedge clk);
        rd_chk("R7 rise pends", 12'h204, 32'h1);
        wr(12'h244, 32'h1);
        repeat (3) @(negedge clk);
        rd_chk("R7 held high no repend", 12'h204, 32'h0);
        irq_line[32] = 1'b0;
        @(negedge clk);
        irq_line[32] = 1'b1;
        @(negedge clk);
        irq_line[32] = 1'b0;
        repeat (2) @(negedge clk);
        rd_chk("R7 short pulse pends", 12'h204, 32'h1);
        wr(12'h244, 32'h1);
        rd_chk("R7 cleared", 12'h204, 32'h0);
    endtask

    task automatic t_level();
        @(negedge clk);
        irq_line[33] = 1'b1;
        repeat (2) @(negedge clk);
        rd_chk("R8 high pends", 12'h204, 32'h2);
        wr(12'h244, 32'h2);
        repeat (2) @(negedge clk);
        rd_chk("R8 clear while high repends", 12'h204, 32'h2);
        irq_line[33] = 1'b0;
        repeat (2) @(negedge clk);
        rd_chk("R8 stays after fall", 12'h204, 32'h2);
        wr(12'h244, 32'h2);
        repeat (2) @(negedge clk);
        rd_chk("R8 cleared when low", 12'h204, 32'h0);
    endtask

    task automatic t_ctrl();
        wr(12'h104, 32'h4);
        wr(12'h204, 32'h4);
        settle();
        out_chk("R9 forwarding off", 1'b0, '0, 8'h00);
        rd_chk("R9 pending latched", 12'h204, 32'h4);
        wr(12'h000, 32'h1);
        settle();
        out_chk("R9 forwarding on", 1'b1, ID_W'(34), 8'h00);
    endtask

    task automatic t_select();
        wr(12'h420, 32'h2040_0000);
        wr(12'h104, 32'h8);
        wr(12'h204, 32'h8);
        settle();
        out_chk("R10 lower value wins", 1'b1, ID_W'(35), 8'h20);
        wr(12'h424, 32'h0000_2000);
        wr(12'h104, 32'h20);
        wr(12'h204, 32'h20);
        settle();
        out_chk("R10 tie lower id", 1'b1, ID_W'(35), 8'h20);
        wr(12'h424, 32'h0000_1000);
        settle();
        out_chk("R10 new best", 1'b1, ID_W'(37), 8'h10);
    endtask

    task automatic t_ack();
        pulse_ack();
        rd_chk("R11 ack sets active", 12'h304, 32'h20);
        rd_chk("R11 ack clears pending", 12'h204, 32'h0C);
        out_chk("R11 withdrawn after ack", 1'b0, '0, 8'h00);
        settle();
        out_chk("R11 next candidate", 1'b1, ID_W'(35), 8'h20);
        wr(12'h204, 32'h20);
        settle();
        out_chk("R13 active excluded", 1'b1, ID_W'(35), 8'h20);
        wr(12'h000, 32'h0);
        @(negedge clk);
        out_chk("R11 no candidate", 1'b0, '0, 8'h00);
        pulse_ack();
        rd_chk("R11 ignored ack active", 12'h304, 32'h20);
        rd_chk("R11 ignored ack pending", 12'h204, 32'h2C);
        wr(12'h000, 32'h1);
    endtask

    task automatic t_deact();
        @(negedge clk);
        deact_id = ID_W'(37);
        deact    = 1'b1;
        @(negedge clk);
        deact    = 1'b0;
        rd_chk("R12 deactivate", 12'h304, 32'h0);
        settle();
        out_chk("R13 returns after deactivate", 1'b1, ID_W'(37), 8'h10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_pending();
        t_active();
        t_prio();
        t_trig();
        t_edge();
        t_level();
        t_ctrl();
        t_select();
        t_ack();
        t_deact();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule